// File: doc/BRIEF.md
# Adaptive Lease Lifetime Predictor

This block sits beside one bank of a shared cache in a design that keeps private copies coherent through leases. Each line granted to a reader is valid until a timestamp, and the reader drops the copy by itself once global time passes that timestamp. The block holds one lease length, in cycles. That length applies to every read served by the bank, and the block tunes it from events the bank reports.

Three event types move the length. A line evicted while its lease is still running means leases are too long, so the length drops by 8. A store hitting a line with a running lease also drops it by 8, and a configuration bit can turn this response off for workloads that issue no fences. A load that finds a valid line whose lease has already run out means leases are too short, so the length rises by 4. Events in the same cycle are added together as signed steps. The sum is then limited once to a configured range, and the result never wraps.

The block combines the current length with the global time to form the grant timestamp for a read. A grant never moves a line's existing timestamp backwards.

Top module: `lease_lifetime_predictor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lifetime_o` equals the parameter `LIFE_INIT`.
- R2: When `evict_live_i` is high alone at a clock edge, `lifetime_o` is 8 lower after that edge, limited below by `LIFE_MIN`.
- R3: When `load_expired_i` is high alone at a clock edge, `lifetime_o` is 4 higher after that edge, limited above by `LIFE_MAX`.
- R4: When `store_live_i` and `store_dec_en_i` are both high, and no other event is present, `lifetime_o` is 8 lower after that edge, limited below by `LIFE_MIN`.
- R5: When `store_dec_en_i` is low, `store_live_i` has no effect on `lifetime_o`.
- R6: Events in one cycle are summed as signed steps (+4 for a load, -8 for an eviction, -8 for an enabled store), and the sum is limited once, so a load with an eviction gives a net -4.
- R7: `lifetime_o` never exceeds `LIFE_MAX`. An increase that would pass it leaves the value at `LIFE_MAX`.
- R8: `lifetime_o` never goes below `LIFE_MIN`, and a minimum of zero is allowed. A decrease that would pass it leaves the value at `LIFE_MIN`.
- R9: `grant_ts_o` equals `now_i + lifetime_o` whenever that sum is larger than `line_ts_i`.
- R10: `grant_ts_o` equals `line_ts_i` whenever `line_ts_i` is not smaller than `now_i + lifetime_o`, so a grant never lowers an existing timestamp.
- R11: With no enabled event in a cycle, `lifetime_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_live_i | input | 1 | A line with a running lease is being evicted |
| load_expired_i | input | 1 | A load found a valid line whose lease has run out |
| store_live_i | input | 1 | A store hit a line whose lease is still running |
| store_dec_en_i | input | 1 | Enables the store-driven decrease |
| now_i | input | TS_W | Global time |
| line_ts_i | input | TS_W | Current timestamp of the line being read |
| lifetime_o | output | LIFE_W | Current predicted lease length in cycles |
| grant_ts_o | output | TS_W | Timestamp to store with the granted line |

## Verification
The assertions check, on every cycle, that the lease length stays inside its range, that it holds when no enabled event is present, and that a disabled store leaves it unchanged. They also check that a lone load never lowers the length and a lone eviction never raises it, and that a grant is never below the line's old timestamp or the current time. Only the bench scenarios show the exact step sizes, the net result of several events in one cycle, the saturation at both limits, the value after reset, and which of the two grant sources is selected.

// File: rtl/lease_lifetime_predictor.sv
module lease_lifetime_predictor #(
  parameter int LIFE_W      = 16,
  parameter int TS_W        = 32,
  parameter int LIFE_MIN    = 0,
  parameter int LIFE_MAX    = 4095,
  parameter int LIFE_INIT   = 256,
  parameter int EVICT_STEP  = 8,
  parameter int STORE_STEP  = 8,
  parameter int EXPIRE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_live_i,
  input  logic              load_expired_i,
  input  logic              store_live_i,
  input  logic              store_dec_en_i,
  input  logic [TS_W-1:0]   now_i,
  input  logic [TS_W-1:0]   line_ts_i,
  output logic [LIFE_W-1:0] lifetime_o,
  output logic [TS_W-1:0]   grant_ts_o
);
  localparam int SW = LIFE_W + 2;
  localparam logic signed [SW-1:0] MIN_S = SW'(LIFE_MIN);
  localparam logic signed [SW-1:0] MAX_S = SW'(LIFE_MAX);
  localparam logic signed [SW-1:0] UP_S  = SW'(EXPIRE_STEP);
  localparam logic signed [SW-1:0] EV_S  = SW'(EVICT_STEP);
  localparam logic signed [SW-1:0] ST_S  = SW'(STORE_STEP);

  logic [LIFE_W-1:0]      life_q;
  logic signed [SW-1:0]   delta, sum, clamped;
  logic [TS_W-1:0]        fresh_ts;

  assign delta = (load_expired_i ? UP_S : '0)
               - (evict_live_i ? EV_S : '0)
               - ((store_live_i && store_dec_en_i) ? ST_S : '0);

  assign sum = $signed({2'b00, life_q}) + delta;

  assign clamped = (sum > MAX_S) ? MAX_S : (sum < MIN_S) ? MIN_S : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) life_q <= LIFE_W'(LIFE_INIT);
    else        life_q <= clamped[LIFE_W-1:0];
  end

  assign lifetime_o = life_q;
  assign fresh_ts   = now_i + TS_W'(life_q);
  assign grant_ts_o = (fresh_ts > line_ts_i) ? fresh_ts : line_ts_i;
endmodule

// File: rtl/lease_lifetime_predictor_checker.sv
module lease_lifetime_predictor_checker #(
  parameter int LIFE_W   = 16,
  parameter int TS_W     = 32,
  parameter int LIFE_MIN = 0,
  parameter int LIFE_MAX = 4095
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evict_live_i,
  input logic              load_expired_i,
  input logic              store_live_i,
  input logic              store_dec_en_i,
  input logic [TS_W-1:0]   now_i,
  input logic [TS_W-1:0]   line_ts_i,
  input logic [LIFE_W-1:0] lifetime_o,
  input logic [TS_W-1:0]   grant_ts_o
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= rst_n;

  assert_upper_bound_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
    int'(lifetime_o) <= LIFE_MAX);

  assert_lower_bound_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
    int'(lifetime_o) >= LIFE_MIN);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!evict_live_i && !load_expired_i && !(store_live_i && store_dec_en_i)) |=> $stable(lifetime_o));

  assert_store_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_live_i && !store_dec_en_i && !evict_live_i && !load_expired_i) |=> $stable(lifetime_o));

  assert_load_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_expired_i && !evict_live_i && !store_live_i) |=> lifetime_o >= $past(lifetime_o));

  assert_evict_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_live_i && !load_expired_i) |=> lifetime_o <= $past(lifetime_o));

  assert_grant_keeps_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_ts_o >= line_ts_i);

  assert_grant_not_past_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (now_i <= ~TS_W'(LIFE_MAX)) |-> grant_ts_o >= now_i);
endmodule

bind lease_lifetime_predictor lease_lifetime_predictor_checker #(
  .LIFE_W(LIFE_W), .TS_W(TS_W), .LIFE_MIN(LIFE_MIN), .LIFE_MAX(LIFE_MAX)
) u_chk (.*);

// File: tb/lease_lifetime_predictor_test.sv
module lease_lifetime_predictor_test;
  localparam int LW = 16, TW = 32, LMIN = 4, LMAX = 40, LINIT = 20;

  logic clk = 0, rst_n = 0;
  logic ev = 0, ld = 0, st = 0, en = 0;
  logic [TW-1:0] now = 0, lts = 0;
  logic [LW-1:0] life;
  logic [TW-1:0] grant;

  always #10 clk = ~clk;

  lease_lifetime_predictor #(.LIFE_W(LW), .TS_W(TW), .LIFE_MIN(LMIN), .LIFE_MAX(LMAX),
    .LIFE_INIT(LINIT)) uut (
    .clk(clk), .rst_n(rst_n), .evict_live_i(ev), .load_expired_i(ld),
    .store_live_i(st), .store_dec_en_i(en), .now_i(now), .line_ts_i(lts),
    .lifetime_o(life), .grant_ts_o(grant));

  typedef struct { int exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, model = LINIT;
  bit done = 0;

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit e, bit l, bit s, bit n, string tag);
    int d;
    @(posedge clk); #1;
    ev = e; ld = l; st = s; en = n;
    d = (l ? 4 : 0) - (e ? 8 : 0) - ((s && n) ? 8 : 0);
    model = model + d;
    if (model > LMAX) model = LMAX;
    if (model < LMIN) model = LMIN;
    @(posedge clk); #1;
    ev = 0; ld = 0; st = 0; en = 0;
    q.push_back('{model, tag});
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(int'(life), it.exp, it.tag);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check(int'(life), LINIT, "R1 during reset");
    rst_n = 1;
    @(negedge clk); check(int'(life), LINIT, "R1 after reset");
    step(1, 0, 0, 0, "R2 evict");
    step(0, 1, 0, 0, "R3 expired load");
    step(0, 0, 1, 1, "R4 store enabled");
    step(0, 0, 1, 0, "R5 store disabled");
    step(0, 0, 0, 0, "R11 idle");
    step(1, 1, 0, 0, "R6 evict plus load");
    step(1, 0, 0, 0, "R8 floor on evict");
    step(1, 0, 1, 1, "R8 floor on two drops");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, "R7 climb to ceiling");
    step(0, 1, 1, 0, "R7 R5 ceiling with masked store");
    step(1, 1, 1, 1, "R6 three events");
    repeat (3) @(posedge clk);
    @(negedge clk);
    now = 1000; lts = 0; #1;
    check(int'(grant), 1000 + int'(life), "R9 fresh grant");
    lts = 5000; #1;
    check(int'(grant), 5000, "R10 keep old timestamp");
    lts = 1000 + TW'(life); #1;
    check(int'(grant), 1000 + int'(life), "R10 equal timestamps");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule